// File: doc/BRIEF.md
# Entropy Seed Health Checker

This block watches the raw serial output of a noise source, one bit for each cycle in which `bit_vld` is high. It looks for two degenerate patterns that show the source has failed. The first is a long run of identical bits. The second is a long run of strict 0/1 alternation. When either pattern passes its threshold, the block raises a live error level and a one-cycle set pulse in the same cycle. A sticky error flag captures the pulse and stays set until software clears it.

The live level follows the stream. It drops at the first accepted bit that no longer breaks a threshold. The sticky flag drops only on an explicit clear strobe. Pulling the enable input low discards all pattern history.

Top module: `seed_health_mon`

## Requirements
- R1: After a bit that differs from the previous accepted bit, or after the stream restarts, 64 identical accepted bits leave `err_live` low. The 65th identical accepted bit raises `err_live`. This applies to runs of 0 and runs of 1 alike.
- R2: An alternation pair is an accepted bit that is the inverse of the previous accepted bit. 32 consecutive alternation pairs (33 alternating bits) leave `err_live` low. The 33rd pair (34th bit) raises `err_live`.
- R3: `err_set` is high for exactly one cycle. That cycle is the first cycle in which `err_live` is high after having been low.
- R4: `err_flag` rises in the same cycle as `err_set`. It stays high while the pattern ends and `err_live` falls.
- R5: A high `flag_clr` at a clock edge clears `err_flag`. If a new error is set at the same edge, the flag stays high.
- R6: An accepted bit that differs from the previous one restarts the identical-run count at 1.
- R7: Two neighbouring equal accepted bits restart the alternation count at 0.
- R8: `err_live` is updated at every accepted bit. It goes low at the first accepted bit after which neither threshold is exceeded.
- R9: While `en` is low, no bit is accepted and both counts and the pattern history are discarded. `err_live` goes low and `err_set` stays low. Counting restarts from nothing once `en` returns high.
- R10: Cycles in which `bit_vld` is low do not change any count, whatever value `bit_in` has.
- R11: After synchronous reset, `err_live`, `err_set` and `err_flag` are low.
- R12: Both counts saturate once their threshold is exceeded. An arbitrarily long bad pattern keeps `err_live` high and never wraps back to a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Checker enable; low discards all history |
| bit_vld | input | 1 | Strobe: `bit_in` is a new sample this cycle |
| bit_in | input | 1 | Noise source bit |
| flag_clr | input | 1 | Software clear of the sticky flag |
| err_live | output | 1 | Current seed error status |
| err_set | output | 1 | One-cycle pulse when an error is first detected |
| err_flag | output | 1 | Sticky seed error flag |

## Verification
Runs of ones and of zeros are driven up to exactly the threshold and one bit past it. This separates an off-by-one in the run count and shows that both polarities trip it. Alternating streams of 33 and 34 bits do the same for the alternation count. A stream broken by a single equal pair, then resumed, shows whether the alternation count really restarts. Stretches of bits with `en` or `bit_vld` low, placed in the middle of otherwise failing runs, show whether disabled or unstrobed cycles leak into the counts. A clear that coincides with a new detection shows which of the two wins on the sticky flag.

// File: rtl/seed_health_mon.sv
module seed_health_mon #(
  parameter int RUN_LIM = 64,
  parameter int ALT_LIM = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic flag_clr,
  output logic err_live,
  output logic err_set,
  output logic err_flag
);
  localparam int RW = $clog2(RUN_LIM + 2);
  localparam int AW = $clog2(ALT_LIM + 2);
  localparam logic [RW-1:0] RUN_TOP = RW'(RUN_LIM + 1);
  localparam logic [AW-1:0] ALT_TOP = AW'(ALT_LIM + 1);

  logic [RW-1:0] run_q, run_d;
  logic [AW-1:0] alt_q, alt_d;
  logic          have_prev, prev_bit;

  wire same  = have_prev && (bit_in == prev_bit);
  wire flip  = have_prev && (bit_in != prev_bit);
  wire take  = en && bit_vld;

  assign run_d = !same ? RW'(1) : (run_q == RUN_TOP) ? run_q : run_q + RW'(1);
  assign alt_d = !flip ? '0     : (alt_q == ALT_TOP) ? alt_q : alt_q + AW'(1);

  wire trip   = (run_d > RW'(RUN_LIM)) || (alt_d > AW'(ALT_LIM));
  wire new_er = take && trip && !err_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      alt_q     <= '0;
      have_prev <= 1'b0;
      prev_bit  <= 1'b0;
      err_live  <= 1'b0;
      err_set   <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      err_set <= new_er;
      if (!en) begin
        run_q     <= '0;
        alt_q     <= '0;
        have_prev <= 1'b0;
        err_live  <= 1'b0;
      end else if (bit_vld) begin
        run_q     <= run_d;
        alt_q     <= alt_d;
        prev_bit  <= bit_in;
        have_prev <= 1'b1;
        err_live  <= trip;
      end
      if (new_er)        err_flag <= 1'b1;
      else if (flag_clr) err_flag <= 1'b0;
    end
  end

  a_r1_run_flags: assert property (@(posedge clk) disable iff (rst)
    (run_q > RW'(RUN_LIM)) |-> err_live);
  a_r2_alt_flags: assert property (@(posedge clk) disable iff (rst)
    (alt_q > AW'(ALT_LIM)) |-> err_live);
  a_r3_set_with_live: assert property (@(posedge clk) disable iff (rst)
    err_set |-> (err_live && !$past(err_live)));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    err_set |=> !err_set);
  a_r4_flag_with_set: assert property (@(posedge clk) disable iff (rst)
    err_set |-> err_flag);
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(err_flag) && !$past(flag_clr)) |-> err_flag);
  a_r9_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!err_set && !err_live));
  a_r10_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(bit_vld)) |-> ($stable(run_q) && $stable(alt_q) && $stable(err_live)));
  a_r12_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (run_q <= RUN_TOP) && (alt_q <= ALT_TOP));
endmodule

// File: tb/test_seed_health_mon.sv
module test_seed_health_mon;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, flag_clr = 1'b0;
  logic err_live, err_set, err_flag;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seed_health_mon i_seed_health_mon (
    .clk(clk), .rst(rst), .en(en), .bit_vld(bit_vld), .bit_in(bit_in),
    .flag_clr(flag_clr), .err_live(err_live), .err_set(err_set), .err_flag(err_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic b);
    @(negedge clk); bit_vld = 1'b1; bit_in = b;
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic push_n(input logic b, input int n);
    for (int i = 0; i < n; i++) push(b);
  endtask

  task automatic push_alt(input logic first, input int n);
    for (int i = 0; i < n; i++) push(first ^ logic'(i[0]));
  endtask

  task automatic restart;
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic clear_flag;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 live", err_live, 1'b0);
    chk("R11 set", err_set, 1'b0);
    chk("R11 flag", err_flag, 1'b0);
  endtask

  task automatic t_run_ones;
    restart();
    push_n(1'b1, 64);
    chk("R1 64 ones", err_live, 1'b0);
    push(1'b1);
    chk("R1 65 ones", err_live, 1'b1);
    chk("R3 set with live", err_set, 1'b1);
    chk("R4 flag with set", err_flag, 1'b1);
    @(negedge clk);
    chk("R3 one cycle", err_set, 1'b0);
    push_n(1'b1, 200);
    chk("R12 long run stays", err_live, 1'b1);
    chk("R3 no repeat pulse", err_set, 1'b0);
    push(1'b0);
    chk("R8 live drops", err_live, 1'b0);
    chk("R4 flag sticky", err_flag, 1'b1);
    clear_flag();
    chk("R5 clear", err_flag, 1'b0);
  endtask

  task automatic t_run_restart;
    push_n(1'b0, 63);
    chk("R6 64 zeros after break", err_live, 1'b0);
    push(1'b0);
    chk("R1 65 zeros", err_live, 1'b1);
    chk("R3 zeros set", err_set, 1'b1);
    push(1'b1);
    push_n(1'b1, 63);
    chk("R6 restart at 1", err_live, 1'b0);
    push(1'b1);
    chk("R6 then 65th", err_live, 1'b1);
    push(1'b0);
    clear_flag();
  endtask

  task automatic t_alt;
    restart();
    push_alt(1'b0, 33);
    chk("R2 32 pairs", err_live, 1'b0);
    push(1'b1);
    chk("R2 33 pairs", err_live, 1'b1);
    chk("R2 set", err_set, 1'b1);
    push(1'b1);
    chk("R7 equal pair clears", err_live, 1'b0);
    push_alt(1'b0, 32);
    chk("R7 restart 32 pairs", err_live, 1'b0);
    push(1'b0);
    chk("R7 restart 33 pairs", err_live, 1'b1);
    push_alt(1'b1, 100);
    chk("R12 long alternation stays", err_live, 1'b1);
    push(1'b0);
    clear_flag();
  endtask

  task automatic t_enable;
    restart();
    push_n(1'b1, 40);
    restart();
    push_n(1'b1, 40);
    chk("R9 counts restart", err_live, 1'b0);
    push_n(1'b1, 30);
    chk("R9 live after 70", err_live, 1'b1);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R9 live low when off", err_live, 1'b0);
    @(negedge clk); bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    chk("R9 no set when off", err_set, 1'b0);
    bit_vld = 1'b0; en = 1'b1;
    clear_flag();
  endtask

  task automatic t_strobe;
    restart();
    push_n(1'b1, 64);
    @(negedge clk); bit_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 idle ignored", err_live, 1'b0);
    push(1'b1);
    chk("R10 run continues", err_live, 1'b1);
    push(1'b0);
    clear_flag();
  endtask

  task automatic t_clr_race;
    restart();
    push_n(1'b1, 64);
    @(negedge clk); bit_vld = 1'b1; bit_in = 1'b1; flag_clr = 1'b1;
    @(negedge clk); bit_vld = 1'b0; flag_clr = 1'b0;
    chk("R5 set beats clear", err_flag, 1'b1);
    clear_flag();
    chk("R5 later clear", err_flag, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    en = 1'b1;
    t_run_ones();
    t_run_restart();
    t_alt();
    t_enable();
    t_strobe();
    t_clr_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule